// File: doc/BRIEF.md
# Banked File-Register AND Unit

This block executes one logical operation: it ANDs an 8-bit working register with one byte of a banked data memory. It recognises a single 16-bit instruction pattern. The instruction carries three fields: an 8-bit file address, a bank-mode bit and a destination bit. When the bank-mode bit is set, the effective 12-bit data address is the 4-bit bank select register followed by the file address. When it is clear, a fixed access window applies. File addresses below 60h reach the bottom of bank 0, and 60h and above reach the top of bank 15. The result goes either to the working register or back to the addressed byte. Only the negative and zero status flags are updated.

Each accepted instruction passes through five sequencer states: IDLE, DECODE, READ, PROCESS and WRITE. The IDLE to DECODE transition is taken only when a valid strobe arrives with a matching opcode. DECODE to READ, READ to PROCESS and PROCESS to WRITE are unconditional. WRITE to IDLE commits the result and raises a one-cycle done pulse. A host side can load the working register, the bank select register and the status register, and can read or write the data memory. The host side is honoured only while the sequencer is in IDLE.

The data memory stores banks 0 to DATA_BANKS-1 and the upper 160 bytes of bank 15. Every other address reads as zero and drops writes.

Top module: `bank_and_unit`

## Requirements
- R1: An instruction is accepted only when `instr_valid_i` is high in IDLE and bits 15:10 equal 000101. Bit 9 is the destination bit d, bit 8 is the bank-mode bit a, and bits 7:0 are the file address f. Any other pattern leaves the state, the registers and `done_o` untouched.
- R2: After the accepting clock edge, `busy_o` is high for four cycles (DECODE, READ, PROCESS, WRITE). `done_o` is high for exactly the one cycle that follows, and the results are visible in that cycle.
- R3: The result is the bitwise AND of the working register and the addressed byte.
- R4: With d=0 the result replaces the working register and memory is unchanged. With d=1 the result is written to the addressed byte and the working register is unchanged.
- R5: With a=1 the data address is {BSR, f}.
- R6: With a=0, f in 00h..5Fh addresses 000h..05Fh, and f in 60h..FFh addresses F60h..FFFh.
- R7: `status_o` bit positions are C=0, DC=1, Z=2, OV=3 and N=4. N takes result bit 7 and Z is set when the result is 00h. C, DC and OV keep their values.
- R8: Strobes that arrive while `busy_o` is high are ignored: no second execution takes place and no extra done pulse is given.
- R9: Host loads of W, BSR and status, and host memory writes, take effect at the next clock edge only when `busy_o` is low. The cycle in which `done_o` is high counts as such a cycle. While `busy_o` is high these loads and writes are ignored.
- R10: With DATA_BANKS=2, addresses in banks 2 to 14, and bank-15 offsets below 60h, read as 00h and ignore writes.
- R11: After reset, W=00h, BSR=0, status=00h, and `busy_o` and `done_o` are both low.
- R12: With W=17h and the addressed byte at C2h, a d=0 instruction gives W=02h and leaves the byte at C2h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction strobe |
| busy_o | output | 1 | Sequencer outside IDLE |
| done_o | output | 1 | One-cycle completion pulse |
| w_ld_i | input | 1 | Load working register |
| w_ld_data_i | input | 8 | Working register load value |
| w_o | output | 8 | Working register |
| bsr_ld_i | input | 1 | Load bank select register |
| bsr_ld_data_i | input | BSR_W (4) | Bank select load value |
| bsr_o | output | BSR_W (4) | Bank select register |
| stat_ld_i | input | 1 | Load status register |
| stat_ld_data_i | input | 5 | Status load value |
| status_o | output | 5 | Status {N,OV,Z,DC,C} |
| host_wr_i | input | 1 | Host memory write |
| host_addr_i | input | BSR_W+8 (12) | Host memory address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (combinational) |

## Verification
The done pulse of one instruction can share its cycle with the acceptance of the next instruction and with a host load of the working register. The bench provokes this by driving a new strobe and a W load in the very cycle `done_o` is seen high, right after a d=1 write to the same file address. The second result is judged against the AND of the newly loaded W and the byte the first instruction wrote. That one value proves that the load, the acceptance and the memory write-back were all ordered correctly.

// File: rtl/bank_and_pkg.sv
package bank_and_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_READ,
        S_PROCESS,
        S_WRITE
    } phase_e;

    localparam logic [5:0] OPC_AND_FILE = 6'b000101;

    localparam int ST_W   = 5;
    localparam int ST_C   = 0;
    localparam int ST_DC  = 1;
    localparam int ST_Z   = 2;
    localparam int ST_OV  = 3;
    localparam int ST_N   = 4;

    typedef struct packed {
        logic       hit;
        logic       dest;
        logic       bank_mode;
        logic [7:0] file;
    } dec_t;

endpackage

// File: rtl/bank_and_decode.sv
module bank_and_decode
    import bank_and_pkg::*;
(
    input  logic [15:0] instr_i,
    output dec_t        dec_o
);

    always_comb begin
        dec_o.hit       = (instr_i[15:10] == OPC_AND_FILE);
        dec_o.dest      = instr_i[9];
        dec_o.bank_mode = instr_i[8];
        dec_o.file      = instr_i[7:0];
    end

endmodule

// File: rtl/bank_and_addr.sv
module bank_and_addr #(
    parameter int BSR_W     = 4,
    parameter int ACC_SPLIT = 96
) (
    input  logic                 bank_mode_i,
    input  logic [7:0]           file_i,
    input  logic [BSR_W-1:0]     bsr_i,
    output logic [BSR_W+8-1:0]   ea_o
);

    localparam logic [7:0] SPLIT = 8'(ACC_SPLIT);

    always_comb begin
        if (bank_mode_i) begin
            ea_o = {bsr_i, file_i};
        end else if (file_i < SPLIT) begin
            ea_o = {{BSR_W{1'b0}}, file_i};
        end else begin
            ea_o = {{BSR_W{1'b1}}, file_i};
        end
    end

endmodule

// File: rtl/bank_and_ram.sv
module bank_and_ram #(
    parameter int BSR_W      = 4,
    parameter int DATA_BANKS = 2,
    parameter int ACC_SPLIT  = 96
) (
    input  logic                 clk,
    input  logic                 core_we_i,
    input  logic [BSR_W+8-1:0]   core_addr_i,
    input  logic [7:0]           core_wdata_i,
    output logic [7:0]           core_rdata_o,
    input  logic                 host_we_i,
    input  logic [BSR_W+8-1:0]   host_addr_i,
    input  logic [7:0]           host_wdata_i,
    output logic [7:0]           host_rdata_o
);

    localparam int ADDR_W   = BSR_W + 8;
    localparam int HI_BYTES = 256 - ACC_SPLIT;
    localparam int DEPTH    = DATA_BANKS * 256 + HI_BYTES;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int TOP_BANK = (1 << BSR_W) - 1;
    localparam int NPORT    = 2;

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic [IDX_W-1:0]  p_idx   [NPORT];
    logic              p_hit   [NPORT];
    logic [7:0]        p_rdata [NPORT];

    assign p_addr[0] = core_addr_i;
    assign p_addr[1] = host_addr_i;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        int bank_n;
        int off_n;
        always_comb begin
            bank_n   = int'(p_addr[p][ADDR_W-1:8]);
            off_n    = int'(p_addr[p][7:0]);
            p_hit[p] = 1'b0;
            p_idx[p] = '0;
            if (bank_n < DATA_BANKS) begin
                p_hit[p] = 1'b1;
                p_idx[p] = IDX_W'(bank_n * 256 + off_n);
            end else if (bank_n == TOP_BANK && off_n >= ACC_SPLIT) begin
                p_hit[p] = 1'b1;
                p_idx[p] = IDX_W'(DATA_BANKS * 256 + off_n - ACC_SPLIT);
            end
            p_rdata[p] = p_hit[p] ? mem[p_idx[p]] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (core_we_i && p_hit[0]) begin
            mem[p_idx[0]] <= core_wdata_i;
        end
        if (host_we_i && p_hit[1]) begin
            mem[p_idx[1]] <= host_wdata_i;
        end
    end

    assign core_rdata_o = p_rdata[0];
    assign host_rdata_o = p_rdata[1];

endmodule

// File: rtl/bank_and_seq.sv
module bank_and_seq
    import bank_and_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_e state_o,
    output logic   done_o
);

    phase_e state_q;
    phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_DECODE;
            S_DECODE:  state_d = S_READ;
            S_READ:    state_d = S_PROCESS;
            S_PROCESS: state_d = S_WRITE;
            S_WRITE:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= (state_q == S_WRITE);
        end
    end

    assign state_o = state_q;

    // R2: the phases follow one another without stalls
    p_phase_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE) |=> (state_q == S_READ));

    p_phase_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROCESS) |=> (state_q == S_WRITE));

    // R2: done follows the write phase and lasts one cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a busy sequencer never restarts before finishing
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ) |=> (state_q != S_DECODE));

endmodule

// File: rtl/bank_and_unit.sv
module bank_and_unit
    import bank_and_pkg::*;
#(
    parameter int BSR_W      = 4,
    parameter int DATA_BANKS = 2,
    parameter int ACC_SPLIT  = 96
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          instr_i,
    input  logic                 instr_valid_i,
    output logic                 busy_o,
    output logic                 done_o,
    input  logic                 w_ld_i,
    input  logic [7:0]           w_ld_data_i,
    output logic [7:0]           w_o,
    input  logic                 bsr_ld_i,
    input  logic [BSR_W-1:0]     bsr_ld_data_i,
    output logic [BSR_W-1:0]     bsr_o,
    input  logic                 stat_ld_i,
    input  logic [4:0]           stat_ld_data_i,
    output logic [4:0]           status_o,
    input  logic                 host_wr_i,
    input  logic [BSR_W+8-1:0]   host_addr_i,
    input  logic [7:0]           host_wdata_i,
    output logic [7:0]           host_rdata_o
);

    localparam int ADDR_W = BSR_W + 8;

    dec_t               dec;
    phase_e             state;
    logic               accept;
    logic               host_ok;
    logic               dest_q;
    logic               mode_q;
    logic [7:0]         file_q;
    logic [ADDR_W-1:0]  ea;
    logic [ADDR_W-1:0]  ea_q;
    logic [7:0]         operand_q;
    logic [7:0]         result_q;
    logic [7:0]         w_q;
    logic [BSR_W-1:0]   bsr_q;
    logic [ST_W-1:0]    stat_q;
    logic               core_we;
    logic [7:0]         core_rdata;

    bank_and_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign accept  = instr_valid_i && dec.hit && (state == S_IDLE);
    assign host_ok = (state == S_IDLE);

    bank_and_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .state_o (state),
        .done_o  (done_o)
    );

    bank_and_addr #(
        .BSR_W     (BSR_W),
        .ACC_SPLIT (ACC_SPLIT)
    ) u_addr (
        .bank_mode_i (mode_q),
        .file_i      (file_q),
        .bsr_i       (bsr_q),
        .ea_o        (ea)
    );

    assign core_we = (state == S_WRITE) && dest_q;

    bank_and_ram #(
        .BSR_W      (BSR_W),
        .DATA_BANKS (DATA_BANKS),
        .ACC_SPLIT  (ACC_SPLIT)
    ) u_ram (
        .clk          (clk),
        .core_we_i    (core_we),
        .core_addr_i  (ea_q),
        .core_wdata_i (result_q),
        .core_rdata_o (core_rdata),
        .host_we_i    (host_wr_i && host_ok),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o)
    );

    // Per-phase datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q    <= 1'b0;
            mode_q    <= 1'b0;
            file_q    <= '0;
            ea_q      <= '0;
            operand_q <= '0;
            result_q  <= '0;
        end else begin
            if (accept) begin
                dest_q <= dec.dest;
                mode_q <= dec.bank_mode;
                file_q <= dec.file;
            end
            if (state == S_DECODE)  ea_q      <= ea;
            if (state == S_READ)    operand_q <= core_rdata;
            if (state == S_PROCESS) result_q  <= w_q & operand_q;
        end
    end

    // Architectural registers: the write phase has priority, host loads only in IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            bsr_q  <= '0;
            stat_q <= '0;
        end else begin
            if (state == S_WRITE) begin
                if (!dest_q) w_q <= result_q;
                stat_q[ST_N] <= result_q[7];
                stat_q[ST_Z] <= (result_q == 8'h00);
            end else if (host_ok) begin
                if (w_ld_i)    w_q    <= w_ld_data_i;
                if (stat_ld_i) stat_q <= stat_ld_data_i;
            end
            if (host_ok && bsr_ld_i) bsr_q <= bsr_ld_data_i;
        end
    end

    assign busy_o   = (state != S_IDLE);
    assign w_o      = w_q;
    assign bsr_o    = bsr_q;
    assign status_o = stat_q;

    // R4: a file-destination instruction never alters W
    p_keep_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE && dest_q) |=> $stable(w_o));

    // R7: carry, digit carry and overflow survive the write phase
    p_other_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |=> (status_o[ST_C] == $past(status_o[ST_C]) &&
                                status_o[ST_DC] == $past(status_o[ST_DC]) &&
                                status_o[ST_OV] == $past(status_o[ST_OV])));

    // R9: host loads are ignored while the sequencer is busy
    p_w_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state != S_WRITE) |=> $stable(w_o));

    p_bsr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(bsr_o));

    // R1: an unrecognised pattern never starts the sequencer
    p_bad_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(instr_valid_i && instr_i[15:10] == OPC_AND_FILE)) |=> !busy_o);

endmodule

// File: tb/tb_bank_and_unit.sv
`timescale 1ns/1ps
module tb_bank_and_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = '0;
    logic        instr_valid_i = 1'b0;
    logic        busy_o, done_o;
    logic        w_ld_i = 1'b0;
    logic [7:0]  w_ld_data_i = '0;
    logic [7:0]  w_o;
    logic        bsr_ld_i = 1'b0;
    logic [3:0]  bsr_ld_data_i = '0;
    logic [3:0]  bsr_o;
    logic        stat_ld_i = 1'b0;
    logic [4:0]  stat_ld_data_i = '0;
    logic [4:0]  status_o;
    logic        host_wr_i = 1'b0;
    logic [11:0] host_addr_i = '0;
    logic [7:0]  host_wdata_i = '0;
    logic [7:0]  host_rdata_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    bank_and_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_valid_i(instr_valid_i),
        .busy_o(busy_o), .done_o(done_o), .w_ld_i(w_ld_i), .w_ld_data_i(w_ld_data_i),
        .w_o(w_o), .bsr_ld_i(bsr_ld_i), .bsr_ld_data_i(bsr_ld_data_i), .bsr_o(bsr_o),
        .stat_ld_i(stat_ld_i), .stat_ld_data_i(stat_ld_data_i), .status_o(status_o),
        .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !ended) begin
            ended = 1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_w(input logic [7:0] v);
        @(negedge clk); w_ld_i = 1'b1; w_ld_data_i = v;
        @(negedge clk); w_ld_i = 1'b0;
    endtask

    task automatic load_bsr(input logic [3:0] v);
        @(negedge clk); bsr_ld_i = 1'b1; bsr_ld_data_i = v;
        @(negedge clk); bsr_ld_i = 1'b0;
    endtask

    task automatic load_stat(input logic [4:0] v);
        @(negedge clk); stat_ld_i = 1'b1; stat_ld_data_i = v;
        @(negedge clk); stat_ld_i = 1'b0;
    endtask

    task automatic poke(input logic [11:0] a, input logic [7:0] v);
        @(negedge clk); host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = v;
        @(negedge clk); host_wr_i = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [7:0] v);
        host_addr_i = a;
        #0.5;
        v = host_rdata_o;
    endtask

    // Issue one instruction and check the done timing (R2)
    task automatic run_instr(input logic [15:0] ins);
        @(negedge clk); instr_i = ins; instr_valid_i = 1'b1;
        @(negedge clk); instr_valid_i = 1'b0;
        chk("R2 busy after accept", busy_o, 1);
        repeat (3) @(negedge clk);
        chk("R2 no early done", done_o, 0);
        @(negedge clk);
        chk("R2 done pulse", done_o, 1);
        chk("R2 idle at done", busy_o, 0);
    endtask

    task automatic t_reset();
        chk("R11 W reset", w_o, 8'h00);
        chk("R11 BSR reset", bsr_o, 4'h0);
        chk("R11 status reset", status_o, 5'h00);
        chk("R11 busy reset", busy_o, 0);
        chk("R11 done reset", done_o, 0);
    endtask

    task automatic t_example();
        logic [7:0] v;
        load_w(8'h17);
        poke(12'h020, 8'hC2);
        run_instr(16'h1420);
        chk("R12 W result", w_o, 8'h02);
        peek(12'h020, v);
        chk("R12 file kept", v, 8'hC2);
        chk("R7 N Z clear", status_o, 5'h00);
    endtask

    task automatic t_dest_file();
        logic [7:0] v;
        load_w(8'hF0);
        poke(12'h035, 8'h3C);
        run_instr(16'h1635);
        peek(12'h035, v);
        chk("R4 file written", v, 8'h30);
        chk("R4 W kept", w_o, 8'hF0);
        chk("R3 and result", v, 8'hF0 & 8'h3C);
    endtask

    task automatic t_banked();
        load_bsr(4'h1);
        poke(12'h1A0, 8'hFF);
        poke(12'h0A0, 8'h00);
        poke(12'hFA0, 8'h00);
        load_w(8'h81);
        run_instr(16'h15A0);
        chk("R5 banked read", w_o, 8'h81);
        chk("R7 N set", status_o[4], 1);
    endtask

    task automatic t_access();
        poke(12'hF70, 8'h5A);
        poke(12'h170, 8'h00);
        load_w(8'hFF);
        run_instr(16'h1470);
        chk("R6 access high", w_o, 8'h5A);
        poke(12'h05F, 8'h0F);
        poke(12'h15F, 8'h00);
        load_w(8'hFF);
        run_instr(16'h145F);
        chk("R6 access low edge 5F", w_o, 8'h0F);
        poke(12'hF60, 8'hA5);
        poke(12'h160, 8'h00);
        load_w(8'hFF);
        run_instr(16'h1460);
        chk("R6 access high edge 60", w_o, 8'hA5);
    endtask

    task automatic t_flags();
        load_stat(5'b01011);
        load_w(8'h0F);
        poke(12'h010, 8'hF0);
        run_instr(16'h1410);
        chk("R7 zero result", w_o, 8'h00);
        chk("R7 Z set others kept", status_o, 5'b01111);
        load_w(8'h80);
        poke(12'h011, 8'hC0);
        run_instr(16'h1411);
        chk("R7 N set Z clear", status_o, 5'b11011);
    endtask

    task automatic t_bad_opcode();
        int seen = 0;
        load_w(8'hFF);
        @(negedge clk); instr_i = 16'h1820; instr_valid_i = 1'b1;
        @(negedge clk); instr_i = 16'h0420;
        @(negedge clk); instr_valid_i = 1'b0;
        chk("R1 not busy", busy_o, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done_o) seen++;
        end
        chk("R1 no done", seen, 0);
        chk("R1 W untouched", w_o, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        int pulses = 0;
        load_bsr(4'h2);
        load_w(8'h33);
        poke(12'h040, 8'h0F);
        poke(12'h041, 8'h11);
        @(negedge clk); instr_i = 16'h1640; instr_valid_i = 1'b1;
        @(negedge clk);
        instr_i = 16'h1440;
        w_ld_i = 1'b1; w_ld_data_i = 8'h99;
        bsr_ld_i = 1'b1; bsr_ld_data_i = 4'h7;
        host_wr_i = 1'b1; host_addr_i = 12'h041; host_wdata_i = 8'hEE;
        repeat (3) @(negedge clk);
        instr_valid_i = 1'b0; w_ld_i = 1'b0; bsr_ld_i = 1'b0; host_wr_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done_o) pulses++;
        end
        chk("R8 single done", pulses, 1);
        chk("R8 idle after", busy_o, 0);
        chk("R9 W load ignored", w_o, 8'h33);
        chk("R9 BSR load ignored", bsr_o, 4'h2);
        peek(12'h041, v);
        chk("R9 host write ignored", v, 8'h11);
        peek(12'h040, v);
        chk("R8 first result only", v, 8'h03);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        poke(12'h300, 8'h77);
        peek(12'h300, v);
        chk("R10 bank 3 reads zero", v, 8'h00);
        poke(12'hF10, 8'h55);
        peek(12'hF10, v);
        chk("R10 bank 15 low reads zero", v, 8'h00);
        load_bsr(4'h3);
        load_w(8'hFF);
        run_instr(16'h1500);
        chk("R10 unmapped operand", w_o, 8'h00);
    endtask

    task automatic t_back_to_back();
        load_w(8'hF3);
        poke(12'h050, 8'h3E);
        run_instr(16'h1650);
        // same cycle as done: new strobe and a W load
        instr_i = 16'h1450; instr_valid_i = 1'b1;
        w_ld_i = 1'b1; w_ld_data_i = 8'h26;
        @(negedge clk);
        instr_valid_i = 1'b0; w_ld_i = 1'b0;
        chk("R9 accept in done cycle", busy_o, 1);
        chk("R9 W load in done cycle", w_o, 8'h26);
        repeat (4) @(negedge clk);
        chk("R2 second done", done_o, 1);
        chk("R3 chained result", w_o, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_dest_file();
        t_banked();
        t_access();
        t_flags();
        t_bad_opcode();
        t_busy_ignore();
        t_unimpl();
        t_back_to_back();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule